// File: doc/BRIEF.md
# Coarse Quadrature Frequency Shifter

This block moves a pair of signed sample streams, A and B, up or down in frequency by a fixed fraction of the sample rate. It uses no multipliers and no oscillator. Each shift is a repeating four-step pattern of sign changes and A/B exchanges. A two-bit phase counter steps through the pattern and advances once for every sample the block accepts. A two-bit mode input selects the pattern, and the same mode applies to both channels. The four modes are straight pass, real half-rate inversion, complex positive quarter-rate rotation and complex negative quarter-rate rotation. When the block runs at half of a final output rate, a quarter-rate rotation appears at that final rate as a shift of one eighth.

Samples enter and leave on valid/ready streams, with one registered stage between them. The input is accepted whenever the output register is empty or is being drained in the same cycle, so `in_ready` is `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output data and `out_valid` hold still and no input is taken. The mode and the sync input are plain control pins. They are sampled together with the sample accepted in the same cycle. A sync forces the pattern back to its first step. Every negation saturates, so the most negative code turns into the most positive one.

Top module: `cqs_mixer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the first accepted sample uses phase 0.
- R2: Mode 00 passes every sample unchanged: out A = A and out B = B on all phases.
- R3: Mode 01 gives out A = +A, -A, +A, -A and out B = +B, -B, +B, -B on phases 0 to 3.
- R4: Mode 10 gives out A = +A, -B, -A, +B and out B = +B, +A, -B, -A on phases 0 to 3.
- R5: Mode 11 gives out A = +A, +B, -A, -B and out B = +B, -A, -B, +A on phases 0 to 3.
- R6: Negation is exact two's complement, except that -32768 becomes +32767. Outputs are 16-bit signed.
- R7: The phase advances by one only on an accepted sample (`in_valid && in_ready`) and wraps from 3 to 0. Idle or stalled cycles leave it unchanged.
- R8: A sample accepted with `sync` high uses phase 0, and the next sample uses phase 1. A `sync` with no sample makes the next accepted sample use phase 0.
- R9: A sample accepted at a clock edge appears on `out_a`/`out_b` with `out_valid` high right after that edge, which is a one-cycle latency in every mode.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_valid`, `out_a` and `out_b` hold their values.
- R11: A mode change applies from the next accepted sample and does not reset the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Shift pattern: 00 pass, 01 half-rate, 10 +quarter, 11 -quarter |
| sync | input | 1 | Restart the pattern at phase 0 |
| in_valid | input | 1 | Input sample pair present |
| in_ready | output | 1 | Block can take the input pair |
| in_a | input | 16 | Input sample A, two's complement |
| in_b | input | 16 | Input sample B, two's complement |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Downstream takes the output pair |
| out_a | output | 16 | Shifted sample A |
| out_b | output | 16 | Shifted sample B |

## Verification
The hardest case to reach from the ports is a downstream stall that lands in the middle of the four-step pattern. In that case the held output must stay frozen, and the waiting input must not consume a phase step. The stimulus first drains the register with an idle cycle, then lowers `out_ready` and pushes one sample. It then presents a second sample for several blocked cycles before releasing the stall, and checks that the second sample comes out on the very next phase. A sweep over every mode, with corner values (including -32768 and +32767) in both lanes and the phase running freely across mode changes, covers the sign and exchange patterns and the saturation. Sync is exercised both with and without a sample present.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
  typedef enum logic [1:0] {
    MIX_PASS = 2'b00,
    MIX_HALF = 2'b01,
    MIX_UP   = 2'b10,
    MIX_DOWN = 2'b11
  } mix_mode_e;

  typedef struct packed {
    logic swap;
    logic neg_a;
    logic neg_b;
  } lane_ctl_t;
endpackage

// File: rtl/cqs_phase.sv
module cqs_phase #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            sync,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] phase_q;

  // sync applies to the sample offered in the same cycle
  assign phase = sync ? '0 : phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (step) phase_q <= phase + PH_W'(1);
    else           phase_q <= phase;
  end

  assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sync) |=> phase_q == $past(phase_q) + PH_W'(1));
  assert_phase_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !sync) |=> $stable(phase_q));
  assert_sync_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && step) |=> phase_q == PH_W'(1));
endmodule

// File: rtl/cqs_decode.sv
module cqs_decode
  import cqs_pkg::*;
(
  input  mix_mode_e   mode,
  input  logic [1:0]  phase,
  output lane_ctl_t   ctl
);
  always_comb begin
    ctl = '{swap: 1'b0, neg_a: 1'b0, neg_b: 1'b0};
    unique case (mode)
      MIX_PASS: ;
      MIX_HALF: begin
        ctl.neg_a = phase[0];
        ctl.neg_b = phase[0];
      end
      MIX_UP: begin
        ctl.swap = phase[0];
        unique case (phase)
          2'd0: ;
          2'd1: ctl.neg_a = 1'b1;
          2'd2: begin ctl.neg_a = 1'b1; ctl.neg_b = 1'b1; end
          2'd3: ctl.neg_b = 1'b1;
          default: ;
        endcase
      end
      MIX_DOWN: begin
        ctl.swap = phase[0];
        unique case (phase)
          2'd0: ;
          2'd1: ctl.neg_b = 1'b1;
          2'd2: begin ctl.neg_a = 1'b1; ctl.neg_b = 1'b1; end
          2'd3: ctl.neg_a = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  // R2: pass mode never disturbs either lane
  always_comb begin
    if (mode == MIX_PASS) assert_pass_clean_R2: assert (!ctl.swap && !ctl.neg_a && !ctl.neg_b);
  end
endmodule

// File: rtl/cqs_lane.sv
module cqs_lane #(
  parameter int W       = 16,
  parameter bit IS_B    = 1'b0
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         swap,
  input  logic         neg,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = ~S_MIN;

  logic [W-1:0] own, other, pick, flipped;

  generate
    if (IS_B) begin : g_lane_b
      assign own   = b_in;
      assign other = a_in;
    end else begin : g_lane_a
      assign own   = a_in;
      assign other = b_in;
    end
  endgenerate

  assign pick    = swap ? other : own;
  assign flipped = (pick == S_MIN) ? S_MAX : (~pick + W'(1));
  assign res     = neg ? flipped : pick;

  // R6: a negated result is never the most negative code
  always_comb begin
    if (neg) assert_no_overflow_R6: assert (res != S_MIN);
  end
endmodule

// File: rtl/cqs_mixer.sv
module cqs_mixer
  import cqs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         sync,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);
  localparam int LANES = 2;
  localparam int PH_W  = 2;
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = ~S_MIN;

  logic            accept;
  logic [PH_W-1:0] phase;
  lane_ctl_t       ctl;
  logic [W-1:0]    lane_res [LANES];
  logic [W-1:0]    a_q, b_q;
  logic            v_q;

  assign in_ready = !v_q || out_ready;
  assign accept   = in_valid && in_ready;

  cqs_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(accept), .sync(sync), .phase(phase)
  );

  cqs_decode u_decode (
    .mode(mix_mode_e'(mode)), .phase(phase), .ctl(ctl)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      cqs_lane #(.W(W), .IS_B(g == 1)) u_lane (
        .a_in(in_a), .b_in(in_b), .swap(ctl.swap),
        .neg(g == 1 ? ctl.neg_b : ctl.neg_a), .res(lane_res[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (accept) begin
        v_q <= 1'b1;
        a_q <= lane_res[0];
        b_q <= lane_res[1];
      end else if (out_ready) begin
        v_q <= 1'b0;
      end
    end
  end

  assign out_valid = v_q;
  assign out_a     = a_q;
  assign out_b     = b_q;

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_a) && $stable(out_b));
  assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b00) |=> out_a == $past(in_a) && out_b == $past(in_b));
  assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b01 && phase[0] && in_a == S_MIN) |=> out_a == S_MAX);
endmodule

// File: tb/cqs_mixer_bench.sv
module cqs_mixer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sync = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [15:0] out_a, out_b;

  int errors = 0;
  int checks = 0;
  int ph = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cqs_mixer u_cqs_mixer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sync(sync),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b)
  );

  function automatic int sneg(input int x);
    return (x == -32768) ? 32767 : -x;
  endfunction

  function automatic void model(input int m, input int p, input int a, input int b,
                                output int ea, output int eb);
    ea = a; eb = b;
    case (m)
      1: if (p % 2 == 1) begin ea = sneg(a); eb = sneg(b); end
      2: case (p)
           1: begin ea = sneg(b); eb = a; end
           2: begin ea = sneg(a); eb = sneg(b); end
           3: begin ea = b; eb = sneg(a); end
           default: ;
         endcase
      3: case (p)
           1: begin ea = b; eb = sneg(a); end
           2: begin ea = sneg(a); eb = sneg(b); end
           3: begin ea = sneg(b); eb = a; end
           default: ;
         endcase
      default: ;
    endcase
  endfunction

  function automatic int corner(input int i);
    case (i)
      0: return -32768;
      1: return -32767;
      2: return -1;
      3: return 0;
      4: return 1;
      5: return 32767;
      6: return 12345;
      default: return -20000;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, accept at posedge, check at following negedge
  task automatic push(input int a, input int b, input int m, input bit s, input string req);
    int eff, ea, eb;
    in_a = a[15:0]; in_b = b[15:0]; mode = m[1:0]; sync = s; in_valid = 1'b1;
    @(posedge clk);
    eff = s ? 0 : ph;
    model(m, eff, a, b, ea, eb);
    ph = (eff + 1) % 4;
    @(negedge clk);
    in_valid = 1'b0; sync = 1'b0;
    check({req, "/R9 valid"}, int'(out_valid), 1);
    check({req, " out_a"}, int'($signed(out_a)), ea);
    check({req, " out_b"}, int'($signed(out_b)), eb);
  endtask

  task automatic idle(input bit s);
    sync = s; in_valid = 1'b0;
    @(posedge clk);
    if (s) ph = 0;
    @(negedge clk);
    sync = 1'b0;
  endtask

  initial begin
    int ea, eb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    // R1: first sample in mode 10 must come out unrotated (phase 0)
    push(100, 200, 2, 1'b0, "R1");
    push(100, 200, 2, 1'b0, "R4");

    // R2..R6, R11: sweep corners in all modes, phase free-running across mode changes
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          push(corner(i), corner(j), m, 1'b0, mode_tag(m));

    // R7: idle cycles do not advance the phase
    idle(1'b0);
    check("R7 idle out_valid", int'(out_valid), 0);
    idle(1'b0);
    push(300, -400, 2, 1'b0, "R7");
    push(300, -400, 3, 1'b0, "R11");

    // R8: sync with a sample, then sync alone
    push(500, 600, 3, 1'b0, "R5");
    push(500, 600, 3, 1'b1, "R8 sync+sample");
    push(500, 600, 3, 1'b0, "R8 after sync");
    idle(1'b1);
    check("R8 idle sync out_valid", int'(out_valid), 0);
    push(-32768, 700, 2, 1'b0, "R8 sync alone");
    push(-32768, 700, 2, 1'b0, "R6");

    // R10: stall mid-pattern
    idle(1'b0);
    out_ready = 1'b0;
    push(1000, 2000, 2, 1'b0, "R10 first");
    model(2, (ph + 3) % 4, 1000, 2000, ea, eb);
    in_a = 16'sd3000; in_b = -16'sd4000; mode = 2'b10; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 in_ready", int'(in_ready), 0);
      check("R10 hold valid", int'(out_valid), 1);
      check("R10 hold a", int'($signed(out_a)), ea);
      check("R10 hold b", int'($signed(out_b)), eb);
    end
    out_ready = 1'b1;
    @(posedge clk);
    model(2, ph, 3000, -4000, ea, eb);
    ph = (ph + 1) % 4;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10/R7 release a", int'($signed(out_a)), ea);
    check("R10/R7 release b", int'($signed(out_b)), eb);
    push(3000, -4000, 2, 1'b0, "R7 after stall");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule